// File: doc/BRIEF.md
# Highway and Farm Road Signal Controller

This block runs the lights where a busy highway crosses a quiet farm road. The highway is green by default. The farm road gets a turn only when a car waits on its sensor and the highway has already had a full long interval of green. A farm green ends when the road empties or when its own long interval runs out. Each green is followed by a yellow that lasts for the short interval.

Two small machines share the work. A four-phase sequencer chooses the colours. An up-counter measures how long the current phase has lasted. The sequencer clears the counter whenever it changes phase. The counter tells the sequencer when the short and long intervals have passed. The sequencer itself only counts phases, and the lengths of the intervals are parameters.

The farm sensor is treated as asynchronous, so it passes through two flip-flops before any decision uses it. The lamp outputs come straight from flip-flops.

Top module: `roadway_signal_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the lamps to highway green and farm red, clears the interval counter and clears the sensor synchroniser. After release, with a car held present, highway yellow appears on the clock edge after the LONG_CYCLES-th edge following release.
- R2: The lamp codes are 2'b00 red, 2'b01 yellow and 2'b10 green. 2'b11 never appears.
- R3: Highway green holds for as long as no car is seen. It moves to highway yellow on the first edge at which a car is seen and at least LONG_CYCLES cycles have passed since the phase began.
- R4: Highway yellow lasts SHORT_CYCLES+1 cycles and then moves to farm green.
- R5: Farm green moves to farm yellow on the first edge at which no car is seen, or at which LONG_CYCLES cycles have passed since the phase began. Otherwise it holds.
- R6: Farm yellow lasts SHORT_CYCLES+1 cycles and then moves to highway green.
- R7: At least one road shows red at all times.
- R8: The interval counter restarts from zero on every phase change and never on a cycle where the phase holds. A second highway green therefore again lasts LONG_CYCLES+1 cycles before yellow while a car is waiting.
- R9: The sensor passes through two flip-flops. A change on `farm_car` takes effect on the third clock edge after it.
- R10: The interval counter saturates at LONG_CYCLES and does not wrap. After any length of idle highway green, a newly arriving car starts the yellow three edges later.
- R11: The lamps are registered and change on the same edge at which the phase changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| farm_car | input | 1 | Farm road car sensor, asynchronous |
| hwy_lamp | output | 2 | Highway lamp code |
| farm_lamp | output | 2 | Farm road lamp code |

## Verification
The hardest cases to reach are the ones that depend on the counter's value when a phase changes. These are a farm green cut short by an empty road, a long idle highway green that has to saturate the counter rather than wrap it, and a reset in the middle of farm green that must leave the counter at zero. The stimulus reaches them through the sensor alone. It drops the car on the cycle farm green begins, holds the highway idle for far longer than the counter range, and asserts reset during farm green with the car still present. The bench then measures the exact cycle of the next yellow to show where the counter started.

// File: rtl/roadway_signal_ctrl.sv
module roadway_signal_ctrl #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       farm_car,
  output logic [1:0] hwy_lamp,
  output logic [1:0] farm_lamp
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYCLES);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYCLES);
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;

  typedef enum logic [1:0] {HWY_GO, HWY_WARN, FARM_GO, FARM_WARN} phase_t;

  phase_t phase, phase_nx;
  logic car_meta, car_seen;
  logic [CW-1:0] ticks;
  logic short_up, long_up, restart;
  logic [1:0] hwy_nx, farm_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      car_meta <= 1'b0;
      car_seen <= 1'b0;
    end else begin
      car_meta <= farm_car;
      car_seen <= car_meta;
    end
  end

  assign short_up = ticks >= SHORT_V;
  assign long_up  = ticks >= LONG_V;

  always_comb begin
    phase_nx = phase;
    case (phase)
      HWY_GO:    if (car_seen && long_up)   phase_nx = HWY_WARN;
      HWY_WARN:  if (short_up)              phase_nx = FARM_GO;
      FARM_GO:   if (!car_seen || long_up)  phase_nx = FARM_WARN;
      FARM_WARN: if (short_up)              phase_nx = HWY_GO;
      default:                              phase_nx = HWY_GO;
    endcase
  end

  assign restart = phase_nx != phase;

  always_ff @(posedge clk) begin
    if (rst || restart) ticks <= '0;
    else if (!long_up)  ticks <= ticks + 1'b1;
  end

  always_comb begin
    hwy_nx  = RED;
    farm_nx = RED;
    case (phase_nx)
      HWY_GO:    hwy_nx  = GRN;
      HWY_WARN:  hwy_nx  = YEL;
      FARM_GO:   farm_nx = GRN;
      FARM_WARN: farm_nx = YEL;
      default:   hwy_nx  = GRN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= HWY_GO;
      hwy_lamp  <= GRN;
      farm_lamp <= RED;
    end else begin
      phase     <= phase_nx;
      hwy_lamp  <= hwy_nx;
      farm_lamp <= farm_nx;
    end
  end

  // R7
  one_red_chk: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp == RED) || (farm_lamp == RED));

  // R2
  lamp_code_chk: assert property (@(posedge clk) disable iff (rst)
    (hwy_lamp != 2'b11) && (farm_lamp != 2'b11));

  // R3
  hwy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == HWY_GO && !car_seen) |=> (phase == HWY_GO && hwy_lamp == GRN));

  // R4
  hwy_warn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == HWY_WARN && !short_up) |=> (phase == HWY_WARN));

  // R6
  farm_warn_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == FARM_WARN && short_up) |=> (phase == HWY_GO && hwy_lamp == GRN));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ticks == '0));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ticks <= LONG_V);

  // R11
  farm_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == FARM_GO) |-> (farm_lamp == GRN && hwy_lamp == RED));
endmodule

// File: tb/roadway_signal_ctrl_test.sv
module roadway_signal_ctrl_test;
  localparam logic [1:0] RED = 2'b00, YEL = 2'b01, GRN = 2'b10;
  localparam int NV = 20;

  // {car, wait cycles, hwy, farm, requirement}; SHORT=2, LONG=5
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'd20, GRN, RED, 4'd3},   // R3 idle highway holds green
    {1'b1, 8'd2,  GRN, RED, 4'd9},   // R9 car not yet through synchroniser
    {1'b1, 8'd1,  YEL, RED, 4'd3},   // R3 leave on third edge
    {1'b1, 8'd2,  YEL, RED, 4'd4},   // R4
    {1'b1, 8'd1,  RED, GRN, 4'd4},   // R4 yellow lasted short+1
    {1'b1, 8'd5,  RED, GRN, 4'd5},   // R5 holds until long
    {1'b1, 8'd1,  RED, YEL, 4'd5},   // R5 long expiry
    {1'b1, 8'd2,  RED, YEL, 4'd6},   // R6
    {1'b1, 8'd1,  GRN, RED, 4'd6},   // R6
    {1'b1, 8'd5,  GRN, RED, 4'd8},   // R8 counter restarted at entry
    {1'b1, 8'd1,  YEL, RED, 4'd8},   // R8
    {1'b1, 8'd2,  YEL, RED, 4'd4},   // R4
    {1'b1, 8'd1,  RED, GRN, 4'd4},   // R4 / R11
    {1'b0, 8'd2,  RED, GRN, 4'd9},   // R9 drop seen after two edges
    {1'b0, 8'd1,  RED, YEL, 4'd5},   // R5 empty road ends green early
    {1'b0, 8'd2,  RED, YEL, 4'd6},   // R6
    {1'b0, 8'd1,  GRN, RED, 4'd6},   // R6
    {1'b0, 8'd30, GRN, RED, 4'd10},  // R10 long idle
    {1'b1, 8'd2,  GRN, RED, 4'd10},  // R10
    {1'b1, 8'd1,  YEL, RED, 4'd10}   // R10 saturated counter, no wrap
  };

  logic clk = 1'b0, rst = 1'b1, farm_car = 1'b0;
  logic [1:0] hwy_lamp, farm_lamp;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  roadway_signal_ctrl #(.SHORT_CYCLES(2), .LONG_CYCLES(5)) uut (
    .clk(clk), .rst(rst), .farm_car(farm_car),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp));

  task automatic check(input logic [1:0] h, input logic [1:0] f, input int req);
    checks++;
    if (hwy_lamp !== h || farm_lamp !== f) begin
      fails++;
      $display("FAIL R%0d: hwy=%0d farm=%0d expected hwy=%0d farm=%0d",
               req, hwy_lamp, farm_lamp, h, f);
    end
  endtask

  // R7 and R2 checked on every cycle out of reset
  always @(negedge clk) if (!rst && !done) begin
    checks++;
    if ((hwy_lamp != RED && farm_lamp != RED) || hwy_lamp == 2'b11 || farm_lamp == 2'b11) begin
      fails++;
      $display("FAIL R7: hwy=%0d farm=%0d expected at least one red (%0d)",
               hwy_lamp, farm_lamp, RED);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(GRN, RED, 1);            // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      farm_car = VEC[i][16];
      repeat (int'(VEC[i][15:8])) @(negedge clk);
      check(VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]));
    end
    farm_car = 1'b1;
    repeat (3) @(negedge clk);
    check(RED, GRN, 5);            // R5 farm green entered
    rst = 1'b1;
    @(negedge clk);
    check(GRN, RED, 1);            // R1 reset mid-phase
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(GRN, RED, 1);            // R1 counter was cleared
    @(negedge clk);
    check(YEL, RED, 1);            // R1 yellow after long+1 edges
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule